// File: doc/BRIEF.md
# Byte Extract, Insert and Mask Unit

This unit is a purely combinational 64-bit datapath. It builds the byte-shuffling steps that software uses to load and store data at addresses that are not naturally aligned. It takes a data operand A, a byte-wide operand B and a 7-bit function code, and it returns one 64-bit result in the same cycle.

For the offset-driven operations, B supplies a byte offset in its three low bits. The unit can clear a field of A, pull a field out of A, or place the low bytes of A at a new position. Each of these comes in a low-half form and a high-half form, at widths of 1, 2, 4 or 8 bytes. The high-half forms cover the bytes that spill past the top of a 64-bit word when the field starts at that offset.

B can also act as an 8-bit byte-select mask, which zeroes whole bytes of A. Three barrel shifts are included as well: logical left, logical right and arithmetic right, by the six low bits of B. Internally, one right shifter serves every right-moving operation. The same shifter, run on a bit-reversed operand, serves every left-moving operation. A per-lane mask generator forms the byte fields.

Top module: `byte_manip_unit`

## Requirements
- R1: Mask-low codes 0x02, 0x12, 0x22, 0x32 (field of 1, 2, 4, 8 bytes) return A with bytes o through o+w-1 cleared, where o = B[2:0]. Bytes at position 8 or above are dropped.
- R2: Mask-high codes 0x52, 0x62, 0x72 (field of 2, 4, 8 bytes) clear byte i of A for every i with i+8 < o+w. When o = 0, the result equals A.
- R3: Extract-low codes 0x06, 0x16, 0x26, 0x36 shift A right logically by 8·o, then keep the low 1, 2, 4 or 8 bytes. All higher bytes are zero.
- R4: Extract-high codes 0x5a, 0x6a, 0x7a shift A left by (64 − 8·o) mod 64, then keep the low 2, 4 or 8 bytes. When o = 0, the result is A masked to that width.
- R5: Insert-low codes 0x0b, 0x1b, 0x2b, 0x3b take the low 1, 2, 4 or 8 bytes of A and shift them left by 8·o, dropping bits beyond bit 63.
- R6: Insert-high codes 0x57, 0x67, 0x77 take the low 2, 4 or 8 bytes of A and shift them right by 64 − 8·o. When o = 0, the result is zero.
- R7: Code 0x30 clears every byte i of A (bits 8i+7..8i) for which B bit i is 1, and passes the other bytes unchanged.
- R8: Code 0x31 clears every byte i of A for which B bit i is 0, and passes the other bytes unchanged.
- R9: Code 0x39 shifts A left logically by B[5:0].
- R10: Code 0x34 shifts A right logically by B[5:0].
- R11: Code 0x3c shifts A right arithmetically by B[5:0], filling with A[63].
- R12: For the mask, extract and insert codes, B[7:3] has no effect on the result.
- R13: Any function code not listed in R1 to R11 returns a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 64 | Data operand A |
| opb | input | 8 | Operand B: byte offset in [2:0], shift amount in [5:0], byte-select mask in [7:0] |
| func | input | 7 | Function code selecting the operation |
| result | output | 64 | Combinational result |

## Verification
The embedded checks run whenever an input changes, so they hold on every cycle. They cover these properties:
- the low-half and high-half byte fields never overlap, and together they always cover exactly the field width;
- a zero shift leaves data unchanged;
- an extract never sets bits outside its field;
- zap and zapnot never leave a selected byte in the wrong state;
- the zero-offset special cases of mask-high and insert-high hold;
- an unlisted code gives zero.

The exact byte placement of every operation at every offset and width can only be shown by the bench. It compares the result against wide-word reference arithmetic, using random and directed operands. The bench also shows that the upper bits of B are ignored and that the arithmetic shift sign-fills.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int FUNC_W = 7;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MSKL,
        OP_MSKH,
        OP_EXTL,
        OP_EXTH,
        OP_INSL,
        OP_INSH,
        OP_ZAP,
        OP_ZAPNOT,
        OP_SLL,
        OP_SRL,
        OP_SRA
    } op_e;

    // function codes; bits [5:4] of the field-width forms give log2 of bytes
    localparam logic [FUNC_W-1:0] FN_MSKBL  = 7'h02;
    localparam logic [FUNC_W-1:0] FN_MSKWL  = 7'h12;
    localparam logic [FUNC_W-1:0] FN_MSKLL  = 7'h22;
    localparam logic [FUNC_W-1:0] FN_MSKQL  = 7'h32;
    localparam logic [FUNC_W-1:0] FN_MSKWH  = 7'h52;
    localparam logic [FUNC_W-1:0] FN_MSKLH  = 7'h62;
    localparam logic [FUNC_W-1:0] FN_MSKQH  = 7'h72;
    localparam logic [FUNC_W-1:0] FN_EXTBL  = 7'h06;
    localparam logic [FUNC_W-1:0] FN_EXTWL  = 7'h16;
    localparam logic [FUNC_W-1:0] FN_EXTLL  = 7'h26;
    localparam logic [FUNC_W-1:0] FN_EXTQL  = 7'h36;
    localparam logic [FUNC_W-1:0] FN_EXTWH  = 7'h5a;
    localparam logic [FUNC_W-1:0] FN_EXTLH  = 7'h6a;
    localparam logic [FUNC_W-1:0] FN_EXTQH  = 7'h7a;
    localparam logic [FUNC_W-1:0] FN_INSBL  = 7'h0b;
    localparam logic [FUNC_W-1:0] FN_INSWL  = 7'h1b;
    localparam logic [FUNC_W-1:0] FN_INSLL  = 7'h2b;
    localparam logic [FUNC_W-1:0] FN_INSQL  = 7'h3b;
    localparam logic [FUNC_W-1:0] FN_INSWH  = 7'h57;
    localparam logic [FUNC_W-1:0] FN_INSLH  = 7'h67;
    localparam logic [FUNC_W-1:0] FN_INSQH  = 7'h77;
    localparam logic [FUNC_W-1:0] FN_ZAP    = 7'h30;
    localparam logic [FUNC_W-1:0] FN_ZAPNOT = 7'h31;
    localparam logic [FUNC_W-1:0] FN_SLL    = 7'h39;
    localparam logic [FUNC_W-1:0] FN_SRL    = 7'h34;
    localparam logic [FUNC_W-1:0] FN_SRA    = 7'h3c;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output op_e               op,
    output logic [1:0]        size_log2
);

    assign size_log2 = func[5:4];

    always_comb begin
        case (func)
            FN_MSKBL, FN_MSKWL, FN_MSKLL, FN_MSKQL: op = OP_MSKL;
            FN_MSKWH, FN_MSKLH, FN_MSKQH:          op = OP_MSKH;
            FN_EXTBL, FN_EXTWL, FN_EXTLL, FN_EXTQL: op = OP_EXTL;
            FN_EXTWH, FN_EXTLH, FN_EXTQH:          op = OP_EXTH;
            FN_INSBL, FN_INSWL, FN_INSLL, FN_INSQL: op = OP_INSL;
            FN_INSWH, FN_INSLH, FN_INSQH:          op = OP_INSH;
            FN_ZAP:                                op = OP_ZAP;
            FN_ZAPNOT:                             op = OP_ZAPNOT;
            FN_SLL:                                op = OP_SLL;
            FN_SRL:                                op = OP_SRL;
            FN_SRA:                                op = OP_SRA;
            default:                               op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/bmu_lane_mask.sv
module bmu_lane_mask #(
    parameter int LANES = 8,
    localparam int OFS_W = $clog2(LANES),
    localparam int WID_W = OFS_W + 1
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [WID_W-1:0] wid,
    output logic [LANES-1:0] lo_lanes,
    output logic [LANES-1:0] hi_lanes,
    output logic [LANES-1:0] fld_lanes
);

    logic [31:0] ofs_x;
    logic [31:0] end_x;

    assign ofs_x = 32'(ofs);
    assign end_x = 32'(ofs) + 32'(wid);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [31:0] IDX = 32'(i);
        // lane inside the field placed at the offset, within this word
        assign lo_lanes[i]  = (IDX >= ofs_x) && (IDX < end_x);
        // lane that the same field reaches after spilling past the top
        assign hi_lanes[i]  = (IDX + 32'(LANES)) < end_x;
        // lane inside the field anchored at lane zero
        assign fld_lanes[i] = IDX < 32'(wid);
    end

    always_comb begin
        // R1
        lanes_disjoint_chk: assert ((lo_lanes & hi_lanes) == '0)
            else $error("low and high lane fields overlap");
        // R2
        lanes_cover_chk: assert (($countones(lo_lanes) + $countones(hi_lanes)) == int'(wid))
            else $error("low and high lanes do not cover field width");
    end

endmodule

// File: rtl/bmu_rshift.sv
module bmu_rshift #(
    parameter int DATA_W = 64,
    localparam int SH_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    input  logic              arith,
    output logic [DATA_W-1:0] dout
);

    logic                          fill;
    logic [SH_W:0][DATA_W-1:0]     stage;

    assign fill     = arith & din[DATA_W-1];
    assign stage[0] = din;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]} : stage[s];
    end

    assign dout = stage[SH_W];

    always_comb begin
        if (amt == '0) begin
            // R9
            shift_zero_chk: assert (dout == din)
                else $error("zero shift altered data");
        end
    end

endmodule

// File: rtl/bmu_lane_expand.sv
module bmu_lane_expand #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        lanes,
    output logic [LANES*LANE_W-1:0] bits
);

    for (genvar i = 0; i < LANES; i++) begin : g_exp
        assign bits[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
    end

endmodule

// File: rtl/byte_manip_unit.sv
module byte_manip_unit
    import bmu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int OFS_W = $clog2(LANES),
    localparam int LSH_W = $clog2(LANE_W),
    localparam int SH_W  = $clog2(DATA_W),
    localparam int B_W   = (LANES > SH_W) ? LANES : SH_W
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [B_W-1:0]    opb,
    input  logic [FUNC_W-1:0] func,
    output logic [DATA_W-1:0] result
);

    op_e               op;
    logic [1:0]        size_log2;
    logic [OFS_W:0]    wid;
    logic [OFS_W-1:0]  ofs;
    logic [OFS_W-1:0]  neg_ofs;
    logic [SH_W-1:0]   bsh;
    logic [LANES-1:0]  zsel;

    logic [LANES-1:0]  lo_lanes, hi_lanes, fld_lanes;
    logic [DATA_W-1:0] lo_bits, hi_bits, fld_bits, zap_bits;
    logic [DATA_W-1:0] a_fld;

    logic [DATA_W-1:0] l_in, l_in_rev, l_out_rev, l_out;
    logic [SH_W-1:0]   l_amt;
    logic [DATA_W-1:0] r_in, r_out;
    logic [SH_W-1:0]   r_amt;
    logic              r_arith;

    bmu_decode u_dec (
        .func      (func),
        .op        (op),
        .size_log2 (size_log2)
    );

    assign ofs     = opb[OFS_W-1:0];
    assign neg_ofs = OFS_W'(0) - ofs;
    assign bsh     = opb[SH_W-1:0];
    assign zsel    = opb[LANES-1:0];
    assign wid     = (32'(size_log2) >= 32'(OFS_W)) ? (OFS_W+1)'(LANES)
                                                   : (OFS_W+1)'(1) << size_log2;

    bmu_lane_mask #(.LANES(LANES)) u_lanes (
        .ofs       (ofs),
        .wid       (wid),
        .lo_lanes  (lo_lanes),
        .hi_lanes  (hi_lanes),
        .fld_lanes (fld_lanes)
    );

    bmu_lane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_exp_lo  (.lanes(lo_lanes),  .bits(lo_bits));
    bmu_lane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_exp_hi  (.lanes(hi_lanes),  .bits(hi_bits));
    bmu_lane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_exp_fld (.lanes(fld_lanes), .bits(fld_bits));
    bmu_lane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_exp_zap (.lanes(zsel),      .bits(zap_bits));

    assign a_fld = opa & fld_bits;

    // shifter operand steering
    always_comb begin
        l_in    = opa;
        l_amt   = bsh;
        r_in    = opa;
        r_amt   = bsh;
        r_arith = 1'b0;
        unique case (op)
            OP_INSL: begin
                l_in  = a_fld;
                l_amt = {ofs, {LSH_W{1'b0}}};
            end
            OP_EXTH: l_amt = {neg_ofs, {LSH_W{1'b0}}};
            OP_EXTL: r_amt = {ofs, {LSH_W{1'b0}}};
            OP_INSH: begin
                r_in  = a_fld;
                r_amt = {neg_ofs, {LSH_W{1'b0}}};
            end
            OP_SRA:  r_arith = 1'b1;
            default: ;
        endcase
    end

    // left shifts reuse the right shifter on a bit-reversed operand
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            l_in_rev[i] = l_in[DATA_W-1-i];
            l_out[i]    = l_out_rev[DATA_W-1-i];
        end
    end

    bmu_rshift #(.DATA_W(DATA_W)) u_lsh (
        .din   (l_in_rev),
        .amt   (l_amt),
        .arith (1'b0),
        .dout  (l_out_rev)
    );

    bmu_rshift #(.DATA_W(DATA_W)) u_rsh (
        .din   (r_in),
        .amt   (r_amt),
        .arith (r_arith),
        .dout  (r_out)
    );

    // result select
    always_comb begin
        unique case (op)
            OP_MSKL:   result = opa & ~lo_bits;
            OP_MSKH:   result = opa & ~hi_bits;
            OP_EXTL:   result = r_out & fld_bits;
            OP_EXTH:   result = l_out & fld_bits;
            OP_INSL:   result = l_out;
            OP_INSH:   result = (ofs == '0) ? '0 : r_out;
            OP_ZAP:    result = opa & ~zap_bits;
            OP_ZAPNOT: result = opa & zap_bits;
            OP_SLL:    result = l_out;
            OP_SRL,
            OP_SRA:    result = r_out;
            default:   result = '0;
        endcase
    end

    always_comb begin
        if (op == OP_MSKH && ofs == '0) begin
            // R2
            mskh_zero_ofs_chk: assert (result == opa)
                else $error("mask-high with zero offset changed A");
        end
        if (op == OP_INSH && ofs == '0) begin
            // R6
            insh_zero_ofs_chk: assert (result == '0)
                else $error("insert-high with zero offset not zero");
        end
        if (op == OP_EXTL || op == OP_EXTH) begin
            // R3
            ext_field_chk: assert ((result & ~fld_bits) == '0)
                else $error("extract set bits outside its field");
        end
        if (op == OP_ZAP) begin
            // R7
            zap_clear_chk: assert ((result & zap_bits) == '0)
                else $error("zap left a selected byte set");
        end
        if (op == OP_ZAPNOT) begin
            // R8
            zapnot_keep_chk: assert ((result & ~zap_bits) == '0)
                else $error("zapnot left an unselected byte set");
        end
        if (op == OP_NONE) begin
            // R13
            unknown_zero_chk: assert (result == '0)
                else $error("unlisted code gave nonzero result");
        end
    end

endmodule

// File: tb/byte_manip_unit_tb.sv
module byte_manip_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa;
    logic [7:0]  opb;
    logic [6:0]  func;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    byte_manip_unit u_dut (
        .opa    (opa),
        .opb    (opb),
        .func   (func),
        .result (result)
    );

    localparam logic [6:0] CODES [26] = '{
        7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
        7'h06, 7'h16, 7'h26, 7'h36, 7'h5a, 7'h6a, 7'h7a,
        7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h57, 7'h67, 7'h77,
        7'h30, 7'h31, 7'h39, 7'h34, 7'h3c
    };

    function automatic string req_tag(input logic [6:0] c);
        case (c)
            7'h02, 7'h12, 7'h22, 7'h32: return "R1";
            7'h52, 7'h62, 7'h72:        return "R2";
            7'h06, 7'h16, 7'h26, 7'h36: return "R3";
            7'h5a, 7'h6a, 7'h7a:        return "R4";
            7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R5";
            7'h57, 7'h67, 7'h77:        return "R6";
            7'h30:                      return "R7";
            7'h31:                      return "R8";
            7'h39:                      return "R9";
            7'h34:                      return "R10";
            7'h3c:                      return "R11";
            default:                    return "R13";
        endcase
    endfunction

    function automatic logic [63:0] low_bytes(input int w);
        return (w >= 8) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << (8 * w)) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_model(input logic [6:0] c, input logic [63:0] a,
                                              input logic [7:0] b);
        int o = int'(b[2:0]);
        int w = 1 << int'(c[5:4]);
        int sh = int'(b[5:0]);
        logic [63:0] fm = low_bytes(w);
        logic [127:0] t;
        logic [63:0] r;
        case (c)
            7'h02, 7'h12, 7'h22, 7'h32: begin
                r = a;
                for (int i = 0; i < 8; i++)
                    if (i >= o && i < o + w) r[8*i +: 8] = 8'h00;
                return r;
            end
            7'h52, 7'h62, 7'h72: begin
                t = {64'd0, fm} << (8 * o);
                return a & ~t[127:64];
            end
            7'h06, 7'h16, 7'h26, 7'h36: return (a >> (8 * o)) & fm;
            7'h5a, 7'h6a, 7'h7a:
                return (o == 0) ? (a & fm) : ((a << (64 - 8 * o)) & fm);
            7'h0b, 7'h1b, 7'h2b, 7'h3b: return (a & fm) << (8 * o);
            7'h57, 7'h67, 7'h77: begin
                t = {64'd0, a & fm} << (8 * o);
                return t[127:64];
            end
            7'h30: begin
                r = a;
                for (int i = 0; i < 8; i++) if (b[i]) r[8*i +: 8] = 8'h00;
                return r;
            end
            7'h31: begin
                r = a;
                for (int i = 0; i < 8; i++) if (!b[i]) r[8*i +: 8] = 8'h00;
                return r;
            end
            7'h39: return a << sh;
            7'h34: return a >> sh;
            7'h3c: return 64'($signed(a) >>> sh);
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s func=%h a=%h b=%h actual=%h expected=%h",
                     tag, func, opa, opb, got, exp);
        end
    endtask

    task automatic apply(input logic [6:0] c, input logic [63:0] a, input logic [7:0] b);
        @(negedge clk);
        func = c;
        opa  = a;
        opb  = b;
        #1;
        check(req_tag(c), result, ref_model(c, a, b));
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] first;
        void'($urandom(32'h5eed_1234));
        func = 7'h00;
        opa  = 64'd0;
        opb  = 8'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R13 reset", result, 64'd0);
        rst_n = 1'b1;

        // directed corners
        apply(7'h72, 64'h0123_4567_89ab_cdef, 8'h00);     // R2 offset zero passes A
        apply(7'h52, 64'h0123_4567_89ab_cdef, 8'h07);     // R2 spill of one byte
        apply(7'h77, 64'hffff_ffff_ffff_ffff, 8'h00);     // R6 offset zero gives zero
        apply(7'h77, 64'h0123_4567_89ab_cdef, 8'h01);     // R6
        apply(7'h7a, 64'h0123_4567_89ab_cdef, 8'h00);     // R4 offset zero
        apply(7'h5a, 64'h0123_4567_89ab_cdef, 8'h07);     // R4
        apply(7'h32, 64'h0123_4567_89ab_cdef, 8'h05);     // R1 truncated field
        apply(7'h06, 64'h0123_4567_89ab_cdef, 8'h07);     // R3 top byte
        apply(7'h3b, 64'h0123_4567_89ab_cdef, 8'h03);     // R5
        apply(7'h30, 64'h0123_4567_89ab_cdef, 8'hff);     // R7 all bytes
        apply(7'h31, 64'h0123_4567_89ab_cdef, 8'h00);     // R8 no bytes kept
        apply(7'h31, 64'h0123_4567_89ab_cdef, 8'h5a);     // R8
        apply(7'h39, 64'h8000_0000_0000_0001, 8'h3f);     // R9 max shift
        apply(7'h34, 64'h8000_0000_0000_0001, 8'h00);     // R10 zero shift
        apply(7'h3c, 64'h8000_0000_0000_0000, 8'h3f);     // R11 sign fill
        apply(7'h3c, 64'h4000_0000_0000_0000, 8'hc1);     // R11 positive, B[7:6] unused
        apply(7'h00, 64'hffff_ffff_ffff_ffff, 8'hff);     // R13
        apply(7'h7f, 64'hffff_ffff_ffff_ffff, 8'h12);     // R13
        apply(7'h42, 64'hffff_ffff_ffff_ffff, 8'h12);     // R13

        // R12: upper bits of B do not change offset-driven results
        for (int k = 0; k < 21; k++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [2:0]  o = 3'($urandom);
            apply(CODES[k], a, {5'b00000, o});
            first = result;
            apply(CODES[k], a, {5'($urandom | 1), o});
            check("R12", result, first);
        end

        // random sweep over every code
        for (int n = 0; n < 150; n++) begin
            for (int k = 0; k < 26; k++) begin
                apply(CODES[k], {$urandom, $urandom}, 8'($urandom));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule